// File: doc/BRIEF.md
# Parallel Conversion Result Port

This block holds the most recent conversion result from a converter's sequencer and presents it on a parallel output bus. The sequencer hands over a finished word together with a one-cycle completion strobe. Only that strobe updates the stored word, so the bus never shows a partly formed value. Reads are gated by an active-low chip select and an active-low read strobe, and by a mode input that gives the pins to a serial path when it is high. The bus is modelled as a data vector plus an output-enable, and the data vector is driven to zero whenever the enable is low.

A host can read after a conversion has finished, during the next acquisition. It can also read while the next conversion is running, in which case it receives the earlier result. A coding input chooses straight binary or two's complement, and it is applied at read time. A status output tells the host whether the conversion in progress is still in its first half, which is the quiet window for reads during conversion.

Top module: `result_bus_port`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, bus_oe, bus_data and conv_early are 0, and the stored result is 0.
- R2: bus_oe is 1 in the cycle after a cycle in which cs_n, rd_n and ser_mode are all 0, and it is 0 in every other cycle.
- R3: While bus_oe is 0, bus_data is all zeros. Holding ser_mode at 1 keeps the bus disabled even when cs_n and rd_n are both 0.
- R4: The stored result changes only in the cycle after done is 1. A change on res_in while done is 0 does not appear on the bus.
- R5: With twos_sel at 0, an enabled bus shows the stored result unchanged (straight binary).
- R6: With twos_sel at 1, an enabled bus shows the stored result with its MSB inverted (two's complement), so 0x0000 reads as 0x8000 and 0xFFFF reads as 0x7FFF.
- R7: A change of twos_sel during a read reaches bus_data one cycle later, without a new conversion.
- R8: While busy is 1 the bus shows the previous result. With cs_n and rd_n held at 0, bus_data changes to the new result two cycles after the cycle in which done is 1.
- R9: Counting from the first cycle in which busy is sampled 1, conv_early is 1 for exactly CONV_CYCLES/2 cycles, beginning one cycle later, and then stays 0 for the rest of that busy period.
- R10: conv_early is 0 in every cycle that follows a cycle in which busy was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 1 gives the pins to the serial path and disables this bus |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read enable |
| twos_sel | input | 1 | 0 selects straight binary, 1 selects two's complement |
| busy | input | 1 | High while a conversion is running |
| done | input | 1 | One-cycle strobe marking res_in as a finished result |
| res_in | input | DATA_W | Result word from the sequencer |
| bus_data | output | DATA_W | Output word, all zeros when not enabled |
| bus_oe | output | 1 | Output enable; 0 means high impedance |
| conv_early | output | 1 | High during the first half of the running conversion |

## Verification
The hardest case to reach is a read that overlaps a conversion: the bus must go on showing the old word while busy is high, and then switch on exactly the right cycle once done arrives. The bench holds cs_n and rd_n low across a whole conversion and samples the bus both in the cycle right after the done strobe and in the cycle after that. It also changes res_in with done held low, to confirm that only the strobe loads a new word.

// File: rtl/result_bus_pkg.sv
package result_bus_pkg;
  typedef enum logic {CODE_BINARY = 1'b0, CODE_TWOS = 1'b1} code_e;
endpackage

// File: rtl/result_hold.sv
module result_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  assert_hold_only_on_load_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/code_fmt.sv
module code_fmt
  import result_bus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  code_e             mode,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] coded
);
  localparam int MSB = DATA_W - 1;
  generate
    if (DATA_W > 1) begin : g_wide
      assign coded = {raw[MSB] ^ (mode == CODE_TWOS), raw[MSB-1:0]};
    end else begin : g_bit
      assign coded = raw ^ (mode == CODE_TWOS);
    end
  endgenerate
endmodule

// File: rtl/half_tracker.sv
module half_tracker #(
  parameter int CONV_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  output logic early
);
  localparam int HALF  = CONV_CYCLES / 2;
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(CONV_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      cnt   <= '0;
      early <= 1'b0;
    end else begin
      early <= (cnt < HALF_C);
      if (cnt != MAX_C) cnt <= cnt + 1'b1;
    end
  end

  assert_early_off_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !early);
  assert_early_needs_busy_R9: assert property (@(posedge clk) disable iff (rst)
    early |-> $past(busy));
endmodule

// File: rtl/result_bus_port.sv
module result_bus_port
  import result_bus_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_mode,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              twos_sel,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] res_in,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              conv_early
);
  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] coded;
  logic              rd_act;

  result_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .load(done), .din(res_in), .q(held)
  );

  code_fmt #(.DATA_W(DATA_W)) u_fmt (
    .mode(code_e'(twos_sel)), .raw(held), .coded(coded)
  );

  half_tracker #(.CONV_CYCLES(CONV_CYCLES)) u_half (
    .clk(clk), .rst(rst), .busy(busy), .early(conv_early)
  );

  assign rd_act = !cs_n && !rd_n && !ser_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe   <= 1'b0;
      bus_data <= '0;
    end else begin
      bus_oe   <= rd_act;
      bus_data <= rd_act ? coded : '0;
    end
  end

  assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_data == '0));
  assert_select_gates_bus_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n || ser_mode) |=> !bus_oe);
  assert_serial_blocks_bus_R3: assert property (@(posedge clk) disable iff (rst)
    ser_mode |=> !bus_oe);
endmodule

// File: tb/result_bus_port_bench.sv
module result_bus_port_bench;
  localparam int W    = 16;
  localparam int CONV = 16;
  localparam int HALF = CONV / 2;

  logic clk = 0, rst = 1;
  logic ser_mode = 0, cs_n = 1, rd_n = 1, twos_sel = 0, busy = 0, done = 0;
  logic [W-1:0] res_in = '0;
  logic [W-1:0] bus_data;
  logic bus_oe, conv_early;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  result_bus_port #(.DATA_W(W), .CONV_CYCLES(CONV)) u_result_bus_port (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .cs_n(cs_n), .rd_n(rd_n),
    .twos_sel(twos_sel), .busy(busy), .done(done), .res_in(res_in),
    .bus_data(bus_data), .bus_oe(bus_oe), .conv_early(conv_early)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [W-1:0] v);
    busy = 1; tick(CONV);
    res_in = v; done = 1; busy = 0; tick(1);
    done = 0;
  endtask

  task automatic t_reset;
    chk("R1 oe", {15'd0, bus_oe}, 0);
    chk("R1 data", bus_data, 0);
    chk("R1 early", {15'd0, conv_early}, 0);
    rst = 0; cs_n = 0; rd_n = 0; tick(2);
    chk("R1 stored zero", bus_data, 0);
    cs_n = 1; rd_n = 1; tick(1);
  endtask

  task automatic t_gating;
    run_conv(16'h1234);
    cs_n = 1; rd_n = 0; tick(1);
    chk("R2 cs high oe", {15'd0, bus_oe}, 0);
    chk("R3 cs high data", bus_data, 0);
    cs_n = 0; rd_n = 1; tick(1);
    chk("R2 rd high oe", {15'd0, bus_oe}, 0);
    rd_n = 0; tick(1);
    chk("R2 read oe", {15'd0, bus_oe}, 1);
    chk("R5 binary", bus_data, 16'h1234);
    ser_mode = 1; tick(1);
    chk("R3 serial oe", {15'd0, bus_oe}, 0);
    chk("R3 serial data", bus_data, 0);
    ser_mode = 0; cs_n = 1; rd_n = 1; tick(1);
  endtask

  task automatic t_coding;
    run_conv(16'h0000);
    cs_n = 0; rd_n = 0; twos_sel = 1; tick(1);
    chk("R6 zero", bus_data, 16'h8000);
    run_conv(16'hFFFF); tick(1);
    chk("R6 full", bus_data, 16'h7FFF);
    twos_sel = 0; tick(1);
    chk("R7 switch", bus_data, 16'hFFFF);
    cs_n = 1; rd_n = 1; tick(1);
  endtask

  task automatic t_no_load;
    run_conv(16'hA5A5);
    res_in = 16'h5A5A; cs_n = 0; rd_n = 0; tick(3);
    chk("R4 ignore res_in", bus_data, 16'hA5A5);
    cs_n = 1; rd_n = 1; tick(1);
  endtask

  task automatic t_during_conv;
    int hi;
    run_conv(16'h0F0F);
    cs_n = 0; rd_n = 0;
    busy = 1; hi = 0;
    for (int i = 0; i < CONV; i++) begin
      tick(1);
      if (i == 0) chk("R9 first", {15'd0, conv_early}, 1);
      if (i == 3) chk("R8 previous", bus_data, 16'h0F0F);
      if (conv_early) hi++;
    end
    chk("R9 count", W'(hi), W'(HALF));
    res_in = 16'hBEEF; done = 1; busy = 0; tick(1);
    done = 0;
    chk("R8 not yet", bus_data, 16'h0F0F);
    tick(1);
    chk("R8 updated", bus_data, 16'hBEEF);
    chk("R10 idle", {15'd0, conv_early}, 0);
    cs_n = 1; rd_n = 1; tick(1);
  endtask

  initial begin
    tick(3);
    t_reset;
    t_gating;
    t_coding;
    t_no_load;
    t_during_conv;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule